// File: doc/BRIEF.md
# Four-way write-through cache controller

This block sits between a 32-bit CPU bus and a simple 32-bit memory port. It holds 4 KB of data as 64 sets of four 16-byte lines. The top three address bits pick how an access is handled. Cached accesses look up all four tags of the indexed set at once. Uncached accesses go straight to memory. The purge region invalidates a single line.

Reads that hit return data without any memory traffic. A read miss replaces the least recently used way of the set and loads the whole line with four long reads. Writes always go through to memory. On a hit they also update the cached bytes, and they never allocate a line.

Software controls the cache through two strobes. One sets or clears the enable bit. The other zeroes the whole cache and turns it off.

Top module: `wt4_cache`

## Requirements
- R1: Address bits 31..29 select the region. 000 is cached and 010 is purge. Every other code bypasses the cache: the access becomes exactly one memory transaction with the same address, size and direction, and it is never cached.
- R2: The tag is address bits 28..10, the set is bits 9..4 and the line offset is bits 3..0. An access whose tag or set differs from a resident line misses.
- R3: A cached read that hits returns its data with no memory transaction. `cpu_rvalid` pulses for one cycle, in the cycle after the request is accepted. Data is big-endian: the lowest byte address is the most significant byte of a word or long. Results are right-justified and zero-extended. Size codes are 0 for byte, 1 for word and 2 for long; accesses are naturally aligned.
- R4: A cached read miss issues four long reads. They start at the line base and go in ascending order. The line becomes valid only after the fourth read is acknowledged. `cpu_rvalid` is raised in the cycle after that acknowledge, and `cpu_busy` stays high throughout.
- R5: Every cached-region write is forwarded to memory. A write hit also merges the written bytes into the line. A write miss allocates nothing.
- R6: Each set keeps a 6-bit pairwise-age state that is updated on every hit and every replacement. From a cleared state, successive misses to one set fill ways 3, 2, 1, 0. Once the set is full, the victim is the way used least recently.
- R7: A long write to the purge region clears the valid bit of the lowest-numbered valid way in the indexed set whose tag matches. The purge makes no memory transaction. Other purge-region accesses have no effect, and purge reads return zero.
- R8: While disabled, cached-region accesses bypass the cache and leave it unchanged. Enabling the cache does not clear its contents.
- R9: The clear strobe invalidates and zeroes every line and every replacement state, and it disables the cache.
- R10: After reset, `cpu_busy`, `cpu_rvalid` and `mem_req` are low and the cache is disabled.
- R11: `mem_req` is held high with a stable `mem_addr` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_en_wr | input | 1 | Strobe that loads the enable bit |
| ctl_en_val | input | 1 | Value loaded into the enable bit |
| ctl_clear | input | 1 | Strobe that clears the whole cache and disables it |
| cpu_req | input | 1 | Access request, accepted when not busy |
| cpu_we | input | 1 | 1 = write |
| cpu_size | input | 2 | 0 byte, 1 word, 2 long |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_busy | output | 1 | High while an access is in progress |
| cpu_rvalid | output | 1 | Read data valid (one-cycle pulse) |
| cpu_rdata | output | 32 | Read data, right-justified |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_size | output | 2 | Memory access size |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, right-justified |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The lookup is tried on several access patterns, each of which separates one behaviour from another.

- **Repeated reads of one line at byte, word and long size.** These separate a fill from a hit. They also catch wrong byte-lane ordering.
- **Addresses that differ from a resident line only in a tag bit or in the set.** These show that each address field takes part in the lookup.
- **Five tags driven into one set, with a hit placed between the misses.** This shows whether the victim follows recency or only fill order.
- **Writes and purges on lines that are present and lines that are absent.** The memory traffic counted after each access shows whether a line was allocated or invalidated. The same traffic count tells bypassed accesses from cached ones.

// File: rtl/wt4_cache.sv
module wt4_cache #(
  parameter int SET_BITS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_en_wr,
  input  logic        ctl_en_val,
  input  logic        ctl_clear,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_busy,
  output logic        cpu_rvalid,
  output logic [31:0] cpu_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int SETS   = 1 << SET_BITS;
  localparam int LINES  = SETS * 4;
  localparam int WORDS  = LINES * 4;
  localparam int TAG_LO = 4 + SET_BITS;
  localparam int TAG_W  = 29 - TAG_LO;

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_FILL, S_RESP} st_t;
  st_t st;

  logic                 en_q;
  logic [31:0]          a_q, wd_q, byp_q;
  logic                 we_q;
  logic [1:0]           sz_q, way_q, fcnt, rsel_q;
  logic [TAG_W-1:0]     tag_mem [LINES];
  logic [31:0]          dat_mem [WORDS];
  logic [LINES-1:0]     vld;
  logic [5:0]           age [SETS];

  function automatic logic [5:0] age_touch(input logic [5:0] s, input logic [1:0] w);
    case (w)
      2'd0:    return s & 6'b000111;
      2'd1:    return (s | 6'b100000) & 6'b111001;
      2'd2:    return (s & 6'b111110) | 6'b010100;
      default: return s | 6'b001011;
    endcase
  endfunction

  function automatic logic [1:0] age_victim(input logic [5:0] s);
    if ((s & 6'b111000) == 6'b111000)      return 2'd0;
    else if ((s & 6'b100110) == 6'b000110) return 2'd1;
    else if ((s & 6'b010101) == 6'b000001) return 2'd2;
    else if ((s & 6'b001011) == 6'b000000) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] lane_pick(input logic [31:0] w, input logic [1:0] off, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'd0, w[31 - 8*off -: 8]};
      2'd1:    return off[1] ? {16'd0, w[15:0]} : {16'd0, w[31:16]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] w, input logic [1:0] off,
                                             input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] r;
    r = w;
    case (sz)
      2'd0:    r[31 - 8*off -: 8] = d[7:0];
      2'd1:    if (off[1]) r[15:0] = d[15:0]; else r[31:16] = d[15:0];
      default: r = d;
    endcase
    return r;
  endfunction

  wire [2:0]          rgn    = cpu_addr[31:29];
  wire [SET_BITS-1:0] set_i  = cpu_addr[TAG_LO-1:4];
  wire [TAG_W-1:0]    tag_i  = cpu_addr[28:TAG_LO];
  wire [SET_BITS-1:0] aset_q = a_q[TAG_LO-1:4];
  wire                accept = (st == S_IDLE) && cpu_req;
  wire                cached = (rgn == 3'b000) && en_q;
  wire                purge  = (rgn == 3'b010);

  logic [3:0] hit_v;
  logic [1:0] hit_way;
  wire        any_hit = |hit_v;
  wire [1:0]  victim  = age_victim(age[set_i]);

  for (genvar g = 0; g < 4; g++) begin : g_cmp
    assign hit_v[g] = vld[{set_i, 2'(g)}] && (tag_mem[{set_i, 2'(g)}] == tag_i);
  end

  always_comb begin
    hit_way = 2'd0;
    for (int w = 3; w >= 0; w--)
      if (hit_v[w]) hit_way = 2'(w);
  end

  // storage: synchronous reset and clear
  always_ff @(posedge clk) begin
    if (!rst_n || ctl_clear) begin
      vld <= '0;
      for (int i = 0; i < LINES; i++) tag_mem[i] <= '0;
      for (int i = 0; i < WORDS; i++) dat_mem[i] <= '0;
      for (int i = 0; i < SETS; i++)  age[i] <= '0;
    end else begin
      if (accept && cached && !cpu_we) begin
        if (any_hit) begin
          age[set_i] <= age_touch(age[set_i], hit_way);
        end else begin
          age[set_i]               <= age_touch(age[set_i], victim);
          tag_mem[{set_i, victim}] <= tag_i;
          vld[{set_i, victim}]     <= 1'b0;
        end
      end
      if (accept && cached && cpu_we && any_hit) begin
        dat_mem[{set_i, hit_way, cpu_addr[3:2]}] <=
          lane_merge(dat_mem[{set_i, hit_way, cpu_addr[3:2]}], cpu_addr[1:0], cpu_size, cpu_wdata);
        age[set_i] <= age_touch(age[set_i], hit_way);
      end
      if (accept && purge && cpu_we && cpu_size == 2'd2 && any_hit)
        vld[{set_i, hit_way}] <= 1'b0;
      if (st == S_FILL && mem_ack) begin
        dat_mem[{aset_q, way_q, fcnt}] <= mem_rdata;
        if (fcnt == 2'd3) vld[{aset_q, way_q}] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (ctl_clear) en_q <= 1'b0;
    else if (ctl_en_wr) en_q <= ctl_en_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; a_q <= '0; wd_q <= '0; we_q <= 1'b0; sz_q <= '0;
      way_q <= '0; fcnt <= '0; rsel_q <= '0; byp_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          a_q <= cpu_addr; wd_q <= cpu_wdata; we_q <= cpu_we; sz_q <= cpu_size;
          if (purge) begin
            rsel_q <= 2'd2;
            st     <= cpu_we ? S_IDLE : S_RESP;
          end else if (cached && !cpu_we) begin
            if (any_hit) begin
              way_q <= hit_way; rsel_q <= 2'd0; st <= S_RESP;
            end else begin
              way_q <= victim; fcnt <= 2'd0; st <= S_FILL;
            end
          end else begin
            st <= S_MEM;
          end
        end
        S_MEM: if (mem_ack) begin
          if (we_q) st <= S_IDLE;
          else begin
            byp_q <= mem_rdata & size_mask(sz_q); rsel_q <= 2'd1; st <= S_RESP;
          end
        end
        S_FILL: if (mem_ack) begin
          fcnt <= fcnt + 2'd1;
          if (fcnt == 2'd3) begin rsel_q <= 2'd0; st <= S_RESP; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cpu_busy   = (st != S_IDLE);
  assign cpu_rvalid = (st == S_RESP);
  assign cpu_rdata  = (rsel_q == 2'd0) ? lane_pick(dat_mem[{aset_q, way_q, a_q[3:2]}], a_q[1:0], sz_q) :
                      (rsel_q == 2'd1) ? byp_q : 32'd0;
  assign mem_req    = (st == S_MEM) || (st == S_FILL);
  assign mem_we     = (st == S_MEM) && we_q;
  assign mem_size   = (st == S_FILL) ? 2'd2 : sz_q;
  assign mem_addr   = (st == S_FILL) ? {a_q[31:4], fcnt, 2'b00} : a_q;
  assign mem_wdata  = wd_q;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |=> !cpu_rvalid);
  assert_fill_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FILL && mem_ack && fcnt == 2'd3 |=> cpu_rvalid);
  assert_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) > $countones($past(vld)) |-> $past(st == S_FILL && mem_ack));
  assert_purge_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && purge |=> !mem_req);
  assert_clear_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |=> vld == '0 && !en_q);
endmodule

// File: tb/wt4_cache_bench.sv
module wt4_cache_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_en_wr = 0, ctl_en_val = 0, ctl_clear = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [1:0] cpu_size = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_busy, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [1:0] mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic mem_ack = 0;

  wt4_cache u_wt4_cache (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int txn = 0, lat_cfg = 0, wcnt = 0, hs_bad = 0, last_ack = 0;
  bit waiting = 0;
  logic [31:0] seen_addr;
  logic [31:0] lg_addr [16];
  logic [31:0] lg_wd [16];
  logic [1:0]  lg_sz [16];
  logic        lg_we [16];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction
  function automatic logic [31:0] msk(input logic [1:0] s);
    return s == 0 ? 32'hFF : s == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (!waiting) begin waiting = 1; seen_addr = mem_addr; wcnt = 0; end
      if (mem_addr !== seen_addr) hs_bad++;
      if (wcnt >= lat_cfg) begin
        mem_ack = 1; waiting = 0; last_ack = cyc;
        mem_rdata = pat(mem_addr) & msk(mem_size);
        lg_addr[txn & 15] = mem_addr; lg_we[txn & 15] = mem_we;
        lg_sz[txn & 15] = mem_size;  lg_wd[txn & 15] = mem_wdata;
        txn++;
      end else wcnt++;
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog (R4) actual=timeout expected=completion");
    summary; $finish;
  end

  task automatic eq(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++; $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  logic [31:0] rd; int lat, rvc;

  task automatic op(input bit we, input logic [1:0] sz, input logic [31:0] ad, input logic [31:0] wd);
    while (cpu_busy) @(negedge clk);
    txn = 0;
    cpu_req = 1; cpu_we = we; cpu_size = sz; cpu_addr = ad; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0; lat = 1;
    if (!we) begin
      while (!cpu_rvalid) begin @(negedge clk); lat++; end
      rd = cpu_rdata; rvc = cyc;
    end else begin
      while (cpu_busy) @(negedge clk);
      rd = 0;
    end
  endtask

  task automatic set_en(input bit v);
    ctl_en_wr = 1; ctl_en_val = v; @(negedge clk); ctl_en_wr = 0;
  endtask

  task automatic t_reset;
    eq("R10 busy", 32'(cpu_busy), 0);
    eq("R10 rvalid", 32'(cpu_rvalid), 0);
    eq("R10 mem_req", 32'(mem_req), 0);
    op(0, 0, 32'h0600_0125, 0);
    eq("R10 disabled bypass txn", txn, 1);
    eq("R10 bypass size", 32'(lg_sz[0]), 0);
    eq("R10 bypass data", rd, pat(32'h0600_0125) & 32'hFF);
  endtask

  task automatic t_fill;
    logic [31:0] w0, w2;
    w0 = pat(32'h0600_0124); w2 = pat(32'h0600_0128);
    lat_cfg = 2;
    op(0, 2, 32'h0600_0124, 0);
    eq("R4 fill txn", txn, 4);
    for (int i = 0; i < 4; i++) begin
      eq("R4 fill addr", lg_addr[i], 32'h0600_0120 + 32'(4 * i));
      eq("R4 fill kind", {29'd0, lg_we[i], lg_sz[i]}, 32'd2);
    end
    eq("R4 fill data", rd, w0);
    eq("R4 rvalid after last ack", rvc, last_ack + 1);
    lat_cfg = 0;
    op(0, 0, 32'h0600_0127, 0);
    eq("R3 hit txn", txn, 0);
    eq("R3 hit latency", lat, 1);
    eq("R3 byte lane 3", rd, {24'd0, w0[7:0]});
    op(0, 0, 32'h0600_0124, 0);
    eq("R3 byte lane 0", rd, {24'd0, w0[31:24]});
    op(0, 1, 32'h0600_012A, 0);
    eq("R3 low half", rd, {16'd0, w2[15:0]});
    op(0, 1, 32'h0600_0128, 0);
    eq("R3 high half", rd, {16'd0, w2[31:16]});
    eq("R3 word hit txn", txn, 0);
    op(0, 2, 32'h0600_0524, 0);
    eq("R2 tag bit10 miss", txn, 4);
    op(0, 2, 32'h0600_0134, 0);
    eq("R2 other set miss", txn, 4);
    op(0, 2, 32'h1600_0124, 0);
    eq("R2 tag bit28 miss", txn, 4);
  endtask

  task automatic t_bypass;
    op(0, 2, 32'h2600_0124, 0);
    eq("R1 through txn", txn, 1);
    eq("R1 through addr", lg_addr[0], 32'h2600_0124);
    eq("R1 through data", rd, pat(32'h2600_0124));
    op(0, 2, 32'h2600_0124, 0);
    eq("R1 through repeat txn", txn, 1);
    op(0, 1, 32'hE000_0102, 0);
    eq("R1 io txn", txn, 1);
    eq("R1 io size", 32'(lg_sz[0]), 1);
    eq("R1 io data", rd, pat(32'hE000_0102) & 32'hFFFF);
    op(1, 2, 32'h6000_0040, 32'h1234_5678);
    eq("R1 region 011 write", {lg_we[0], lg_wd[0][30:0]}, {1'b1, 31'h1234_5678});
  endtask

  task automatic t_write;
    logic [31:0] w0;
    w0 = pat(32'h0600_0124);
    op(1, 1, 32'h0600_0126, 32'h0000_BEEF);
    eq("R5 wt txn", txn, 1);
    eq("R5 wt addr", lg_addr[0], 32'h0600_0126);
    eq("R5 wt kind", {29'd0, lg_we[0], lg_sz[0]}, 32'd5);
    eq("R5 wt data", lg_wd[0], 32'h0000_BEEF);
    op(0, 2, 32'h0600_0124, 0);
    eq("R5 merged word txn", txn, 0);
    eq("R5 merged half", rd, {w0[31:16], 16'hBEEF});
    op(1, 0, 32'h0600_0124, 32'h0000_005A);
    op(0, 2, 32'h0600_0124, 0);
    eq("R5 merged byte", rd, {8'h5A, w0[23:16], 16'hBEEF});
    op(1, 2, 32'h0600_2000, 32'hCAFE_F00D);
    eq("R5 write miss txn", txn, 1);
    op(0, 2, 32'h0600_2000, 0);
    eq("R5 no allocate", txn, 4);
  endtask

  task automatic t_lru;
    for (int k = 1; k <= 4; k++) begin
      op(0, 2, 32'h0600_0050 + 32'(k * 32'h400), 0);
      eq("R6 initial fill", txn, 4);
    end
    op(0, 2, 32'h0600_0450, 0);
    eq("R6 A hit", txn, 0);
    op(0, 2, 32'h0600_1450, 0);
    eq("R6 E miss", txn, 4);
    op(0, 2, 32'h0600_0C50, 0);
    eq("R6 C kept", txn, 0);
    op(0, 2, 32'h0600_1050, 0);
    eq("R6 D kept", txn, 0);
    op(0, 2, 32'h0600_0450, 0);
    eq("R6 A kept", txn, 0);
    op(0, 2, 32'h0600_0850, 0);
    eq("R6 B evicted", txn, 4);
    eq("R6 B data", rd, pat(32'h0600_0850));
  endtask

  task automatic t_purge;
    op(0, 2, 32'h0600_0090, 0);
    op(0, 2, 32'h0600_0490, 0);
    op(1, 2, 32'h4600_0090, 32'h0);
    eq("R7 purge txn", txn, 0);
    op(0, 2, 32'h0600_0090, 0);
    eq("R7 purged refills", txn, 4);
    op(0, 2, 32'h0600_0490, 0);
    eq("R7 neighbour kept", txn, 0);
    op(0, 2, 32'h4600_0490, 0);
    eq("R7 purge read zero", rd, 0);
    eq("R7 purge read txn", txn, 0);
    op(1, 0, 32'h4600_0490, 32'h0);
    op(0, 2, 32'h0600_0490, 0);
    eq("R7 byte purge ignored", txn, 0);
  endtask

  task automatic t_enable;
    set_en(0);
    op(1, 2, 32'h0600_0490, 32'h1122_3344);
    eq("R8 disabled write txn", txn, 1);
    op(0, 2, 32'h0600_0490, 0);
    eq("R8 disabled read txn", txn, 1);
    eq("R8 disabled read size", 32'(lg_sz[0]), 2);
    set_en(1);
    op(0, 2, 32'h0600_0490, 0);
    eq("R8 contents kept txn", txn, 0);
    eq("R8 untouched by disabled write", rd, pat(32'h0600_0490));
  endtask

  task automatic t_clear;
    ctl_clear = 1; @(negedge clk); ctl_clear = 0;
    op(0, 2, 32'h0600_0490, 0);
    eq("R9 disabled after clear", txn, 1);
    set_en(1);
    op(0, 2, 32'h0600_0490, 0);
    eq("R9 line cleared", txn, 4);
    op(0, 2, 32'h0600_0090, 0);
    eq("R9 other line cleared", txn, 4);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    set_en(1);
    t_fill;
    t_bypass;
    t_write;
    t_lru;
    t_purge;
    t_enable;
    t_clear;
    eq("R11 address stable while waiting", hs_bad, 0);
    summary;
    $finish;
  end
endmodule